// File: doc/BRIEF.md
# Four-Line Serial Audio Receiver with I2S Pass-Through

This block receives stereo PCM audio on four serial data lines as a clock slave. All four lines share one bit clock and one frame clock (word select). Each line carries a left and a right word per frame, so the block delivers eight channels. Both the framing and the word length come from configuration inputs. Framing is left-justified, right-justified or I2S. The word length is 16, 20 or 24 bits. A frame is 48 or 64 bit clocks long, and the block measures this itself.

Each received word is left-aligned into a 24-bit sample. The eight samples are presented together with a one-cycle strobe once per frame. One line, chosen by a parameter, is also sent back out on a single serial output. That output is always 24-bit I2S and is timed by the same bit and frame clocks. It has no configuration of its own.

All logic runs on the rising edge of the bit clock. The frame clock and the data lines are sampled on that edge, and the serial output also changes on that edge.

Top module: `audio_ser_rx`

## Requirements
- R1: Samples are packed into `pcmData` as line L left word at bits [(2L)*24 +: 24] and line L right word at bits [(2L+1)*24 +: 24], for L = 0..3.
- R2: `cfgFormat` encodes 0 = left-justified, 1 = right-justified, 2 = I2S. `cfgLen` encodes 0 = 16 bits, 1 = 20 bits, 2 = 24 bits.
- R3: Left-justified: the MSB is the bit sampled at the same edge as the frame clock change, and frame clock high marks the left word.
- R4: Right-justified: the word is the last N bits of each half-frame, ending just before the frame clock change, and frame clock high marks the left word.
- R5: I2S: the MSB is sampled one bit clock after the frame clock change, and frame clock low marks the left word. When N equals the half-frame length, the LSB falls on the first bit of the next half.
- R6: Words shorter than 24 bits occupy the upper bits of their sample, and the lower bits are zero. Bits of a half-frame outside the word have no effect.
- R7: Half-frames of 24 and of 32 bit clocks (48 or 64 per frame) are both accepted without any setting.
- R8: `pcmValid` is high for exactly one cycle per frame. It follows the edge that samples the frame clock change ending a right word. `pcmData` changes only together with that pulse.
- R9: `sdOut` is 24-bit I2S. Frame clock low marks the left word, and the MSB is presented for the edge one bit clock after the frame clock change. Each bit is updated on a rising edge for sampling at the next rising edge, and zeros follow the LSB.
- R10: `sdOut` carries line `PASS_LINE` (default 3). The left/right pair it sends, starting at a falling frame clock, is the most recent pair completed at or before that edge.
- R11: After reset all outputs are zero. No strobe is produced until a complete left and right word have been received after the first observed frame clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkBit | input | 1 | Serial bit clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low reset, synchronous to clkBit |
| frameClk | input | 1 | Frame clock selecting left or right word |
| sdIn | input | 4 | Four serial data lines, one stereo pair each |
| cfgFormat | input | 2 | Framing select |
| cfgLen | input | 2 | Word length select |
| pcmData | output | 192 | Eight received 24-bit samples |
| pcmValid | output | 1 | One-cycle strobe when a new pair set is presented |
| sdOut | output | 1 | Serial I2S retransmission of the pass line |

## Verification
A miscounted half-frame length or a wrong shift amount shows up in `pcmData` at the very next strobe. It appears as a word shifted by one or more bit positions, so random words with random filler bits expose it within one frame. A wrong channel-polarity decision swaps or delays the pairs, which shows on the strobe following the first complete frame. A stale snapshot for the serial output shows as a word from the wrong frame in the decoded `sdOut` stream within two frames. A miscounted output shift register shows as a bit-shifted word or as non-zero padding within the same half-frame.

// File: rtl/audio_ser_rx_pkg.sv
package audio_ser_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_RIGHT = 2'd1,
    FMT_I2S   = 2'd2,
    FMT_RSVD  = 2'd3
  } frameFmt_e;

  // Strobes and shift amount handed from the control to the datapath.
  typedef struct packed {
    logic       capL;      // left word complete this edge
    logic       capR;      // right word complete this edge
    logic       pairDone;  // right word completes a pair
    logic       loadOutL;  // output enters its left half
    logic       loadOutR;  // output enters its right half
    logic [6:0] shiftAmt;  // word LSB position inside the shift window
  } ctrlStrobes_t;

  function automatic logic [4:0] wordBits(input logic [1:0] lenSel);
    case (lenSel)
      2'd0:    return 5'd16;
      2'd1:    return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/audio_ser_rx_ctrl.sv
module audio_ser_rx_ctrl
  import audio_ser_rx_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int MAX_HALF = 32
) (
  input  logic         clkBit,
  input  logic         rstN,
  input  logic         frameClk,
  input  logic [1:0]   cfgFormat,
  input  logic [1:0]   cfgLen,
  output ctrlStrobes_t ctl
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             lrPrev;
  logic             synced;
  logic             gotLeft;
  logic [CNT_W-1:0] bitCnt;

  logic       edgeSeen;
  logic       endedLeft;
  logic       lenOk;
  logic [4:0] nBits;
  logic [6:0] halfLen;
  frameFmt_e  fmt;

  always_comb begin
    fmt       = frameFmt_e'(cfgFormat);
    nBits     = wordBits(cfgLen);
    edgeSeen  = frameClk != lrPrev;
    // the half that just ended was left: low level for I2S, high otherwise
    endedLeft = (fmt == FMT_I2S) ? ~lrPrev : lrPrev;
    halfLen   = 7'(bitCnt) + 7'd1;
    lenOk     = (halfLen >= {2'b00, nBits}) && (halfLen <= 7'(MAX_HALF));

    ctl          = '0;
    ctl.capL     = edgeSeen & synced & lenOk & endedLeft;
    ctl.capR     = edgeSeen & synced & lenOk & ~endedLeft;
    ctl.pairDone = ctl.capR & gotLeft;
    ctl.loadOutL = edgeSeen & ~frameClk;
    ctl.loadOutR = edgeSeen & frameClk;
    case (fmt)
      FMT_RIGHT: ctl.shiftAmt = 7'd1;
      FMT_I2S:   ctl.shiftAmt = halfLen - {2'b00, nBits};
      default:   ctl.shiftAmt = halfLen - {2'b00, nBits} + 7'd1;
    endcase
  end

  always_ff @(posedge clkBit) begin
    if (!rstN) begin
      lrPrev  <= 1'b0;
      synced  <= 1'b0;
      gotLeft <= 1'b0;
      bitCnt  <= '0;
    end else begin
      lrPrev <= frameClk;
      synced <= synced | edgeSeen;
      if (edgeSeen)              bitCnt <= '0;
      else if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
      if (ctl.capL)          gotLeft <= 1'b1;
      else if (ctl.pairDone) gotLeft <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_ser_rx_dp.sv
module audio_ser_rx_dp
  import audio_ser_rx_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WORD_W    = 24,
  parameter int PASS_LINE = 3,
  parameter int MAX_HALF  = 32
) (
  input  logic                          clkBit,
  input  logic                          rstN,
  input  logic [NUM_LINES-1:0]          sdIn,
  input  logic [1:0]                    cfgLen,
  input  ctrlStrobes_t                  ctl,
  output logic [NUM_LINES*2*WORD_W-1:0] pcmData,
  output logic                          pcmValid,
  output logic                          sdOut
);

  localparam int WIN_W = MAX_HALF + 1;

  logic [4:0]                  nBits;
  logic [4:0]                  padAmt;
  logic [WORD_W-1:0]           lenMask;
  logic [NUM_LINES*WORD_W-1:0] newFlat;
  logic [NUM_LINES*WORD_W-1:0] holdFlat;

  always_comb begin
    nBits   = wordBits(cfgLen);
    padAmt  = 5'(WORD_W) - nBits;
    lenMask = ~({WORD_W{1'b1}} << nBits);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [WIN_W-2:0]  shReg;
    logic [WIN_W-1:0]  shNext;
    logic [WIN_W-1:0]  shifted;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] holdL;
    logic [WORD_W-1:0] outL;
    logic [WORD_W-1:0] outR;

    always_comb begin
      shNext  = {shReg, sdIn[g]};
      shifted = shNext >> ctl.shiftAmt;
      aligned = (shifted[WORD_W-1:0] & lenMask) << padAmt;
    end

    always_ff @(posedge clkBit) begin
      if (!rstN) begin
        shReg <= '0;
        holdL <= '0;
        outL  <= '0;
        outR  <= '0;
      end else begin
        shReg <= shNext[WIN_W-2:0];
        if (ctl.capL) holdL <= aligned;
        if (ctl.pairDone) begin
          outL <= holdL;
          outR <= aligned;
        end
      end
    end

    assign newFlat[g*WORD_W +: WORD_W]          = aligned;
    assign holdFlat[g*WORD_W +: WORD_W]         = holdL;
    assign pcmData[(2*g)*WORD_W +: WORD_W]      = outL;
    assign pcmData[(2*g + 1)*WORD_W +: WORD_W]  = outR;
  end

  // pass-through: snapshot a whole pair when the output left half begins
  logic [WORD_W-1:0] pairL;
  logic [WORD_W-1:0] pairR;
  logic [WORD_W-1:0] snapR;
  logic [WORD_W-1:0] outShift;

  always_comb begin
    if (ctl.pairDone) begin
      pairL = holdFlat[PASS_LINE*WORD_W +: WORD_W];
      pairR = newFlat[PASS_LINE*WORD_W +: WORD_W];
    end else begin
      pairL = pcmData[(2*PASS_LINE)*WORD_W +: WORD_W];
      pairR = pcmData[(2*PASS_LINE + 1)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clkBit) begin
    if (!rstN) begin
      pcmValid <= 1'b0;
      snapR    <= '0;
      outShift <= '0;
    end else begin
      pcmValid <= ctl.pairDone;
      if (ctl.loadOutL) begin
        snapR    <= pairR;
        outShift <= pairL;
      end else if (ctl.loadOutR) begin
        outShift <= snapR;
      end else begin
        outShift <= {outShift[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sdOut = outShift[WORD_W-1];

endmodule

// File: rtl/audio_ser_rx.sv
module audio_ser_rx
  import audio_ser_rx_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WORD_W    = 24,
  parameter int PASS_LINE = 3,
  parameter int MAX_HALF  = 32
) (
  input  logic                          clkBit,
  input  logic                          rstN,
  input  logic                          frameClk,
  input  logic [NUM_LINES-1:0]          sdIn,
  input  logic [1:0]                    cfgFormat,
  input  logic [1:0]                    cfgLen,
  output logic [NUM_LINES*2*WORD_W-1:0] pcmData,
  output logic                          pcmValid,
  output logic                          sdOut
);

  localparam int CNT_W = $clog2(MAX_HALF) + 1;

  ctrlStrobes_t ctl;

  audio_ser_rx_ctrl #(
    .CNT_W    (CNT_W),
    .MAX_HALF (MAX_HALF)
  ) u_ctrl (
    .clkBit    (clkBit),
    .rstN      (rstN),
    .frameClk  (frameClk),
    .cfgFormat (cfgFormat),
    .cfgLen    (cfgLen),
    .ctl       (ctl)
  );

  audio_ser_rx_dp #(
    .NUM_LINES (NUM_LINES),
    .WORD_W    (WORD_W),
    .PASS_LINE (PASS_LINE),
    .MAX_HALF  (MAX_HALF)
  ) u_dp (
    .clkBit   (clkBit),
    .rstN     (rstN),
    .sdIn     (sdIn),
    .cfgLen   (cfgLen),
    .ctl      (ctl),
    .pcmData  (pcmData),
    .pcmValid (pcmValid),
    .sdOut    (sdOut)
  );

endmodule

// File: rtl/audio_ser_rx_chk.sv
module audio_ser_rx_chk #(
  parameter int NUM_LINES = 4,
  parameter int WORD_W    = 24
) (
  input logic                          clkBit,
  input logic                          rstN,
  input logic                          frameClk,
  input logic [1:0]                    cfgFormat,
  input logic [1:0]                    cfgLen,
  input logic [NUM_LINES*2*WORD_W-1:0] pcmData,
  input logic                          pcmValid
);

  AST_STROBE_AT_EDGE: assert property (@(posedge clkBit) disable iff (!rstN)
    pcmValid |-> ($past(frameClk) != $past(frameClk, 2))); // R8

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clkBit) disable iff (!rstN)
    pcmValid |=> !pcmValid); // R8

  AST_PCM_HELD: assert property (@(posedge clkBit) disable iff (!rstN)
    !pcmValid |-> $stable(pcmData)); // R8

  AST_STROBE_PHASE: assert property (@(posedge clkBit) disable iff (!rstN)
    pcmValid |-> ($past(frameClk) == (cfgFormat != 2'd2))); // R5

  for (genvar i = 0; i < 2*NUM_LINES; i++) begin : gPad
    AST_PAD_ZERO: assert property (@(posedge clkBit) disable iff (!rstN)
      (pcmValid && cfgLen == 2'd0) |-> (pcmData[i*WORD_W +: 8] == 8'd0)); // R6
  end

endmodule

bind audio_ser_rx audio_ser_rx_chk #(
  .NUM_LINES (NUM_LINES),
  .WORD_W    (WORD_W)
) u_chk (
  .clkBit    (clkBit),
  .rstN      (rstN),
  .frameClk  (frameClk),
  .cfgFormat (cfgFormat),
  .cfgLen    (cfgLen),
  .pcmData   (pcmData),
  .pcmValid  (pcmValid)
);

// File: tb/tb_audio_ser_rx.sv
module tb_audio_ser_rx;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int W  = 24;
  localparam int PASS = 3;

  logic            clkBit = 1'b0;
  logic            rstN = 1'b0;
  logic            frameClk = 1'b0;
  logic [NL-1:0]   sdIn = '0;
  logic [1:0]      cfgFormat = 2'd0;
  logic [1:0]      cfgLen = 2'd0;
  logic [NL*2*W-1:0] pcmData;
  logic            pcmValid;
  logic            sdOut;

  audio_ser_rx dut (
    .clkBit    (clkBit),
    .rstN      (rstN),
    .frameClk  (frameClk),
    .sdIn      (sdIn),
    .cfgFormat (cfgFormat),
    .cfgLen    (cfgLen),
    .pcmData   (pcmData),
    .pcmValid  (pcmValid),
    .sdOut     (sdOut)
  );

  always #(CLK_PERIOD/2) clkBit = ~clkBit;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] curL [NL];
  logic [W-1:0] curR [NL];
  logic [W-1:0] prevL [NL];
  logic [W-1:0] prevR [NL];
  logic         prevLsb [NL];

  task automatic check(input bit ok, input string tag,
                       input logic [NL*2*W-1:0] act, input logic [NL*2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nOf(input logic [1:0] l);
    return (l == 2'd0) ? 16 : (l == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [W-1:0] alignW(input logic [W-1:0] w, input int n);
    return w << (W - n);
  endfunction

  function automatic logic bitFor(input int fmt, input int n, input int hl, input int p,
                                  input logic [W-1:0] w, input logic plsb, input logic junk);
    if (fmt == 0) return (p < n) ? w[n-1-p] : junk;
    if (fmt == 1) return (p >= hl - n) ? w[hl-1-p] : junk;
    if (p == 0)   return (n == hl) ? plsb : junk;
    return (p <= n) ? w[n-p] : junk;
  endfunction

  function automatic logic [NL*2*W-1:0] expPack(input int n);
    logic [NL*2*W-1:0] v = '0;
    for (int ln = 0; ln < NL; ln++) begin
      v[(2*ln)*W +: W]   = alignW(prevL[ln], n);
      v[(2*ln+1)*W +: W] = alignW(prevR[ln], n);
    end
    return v;
  endfunction

  task automatic runMode(input int fmt, input int lenSel, input int hl, input int nFrames);
    int n = nOf(2'(lenSel));
    logic leftLvl = (fmt == 2) ? 1'b0 : 1'b1;
    string tagFmt;
    int oCnt = 0;
    logic [W-1:0] oAcc = '0, oExp = '0, snapL = '0, snapR = '0;
    bit snapValid = 0, oChk = 0;
    logic [W-1:0] mask = ~({W{1'b1}} << n);
    tagFmt = (fmt == 0) ? "R3 R1 R2 R6 R7" : (fmt == 1) ? "R4 R1 R2 R6 R7" : "R5 R1 R2 R6 R7";

    @(negedge clkBit);
    rstN = 1'b0;
    cfgFormat = 2'(fmt);
    cfgLen = 2'(lenSel);
    frameClk = ~leftLvl;
    sdIn = '0;
    repeat (3) @(negedge clkBit);
    rstN = 1'b1;
    for (int ln = 0; ln < NL; ln++) begin
      prevLsb[ln] = 1'b0;
      curL[ln] = '0;
      curR[ln] = '0;
    end
    repeat (40) @(negedge clkBit);
    // R11: quiet after reset with no frame received
    check(pcmValid === 1'b0 && pcmData === '0 && sdOut === 1'b0, "R11 reset state",
          {pcmData[NL*2*W-3:0], pcmValid, sdOut}, '0);

    for (int k = 0; k < nFrames; k++) begin
      for (int ln = 0; ln < NL; ln++) begin
        prevL[ln] = curL[ln];
        prevR[ln] = curR[ln];
        if (k == 0) begin
          curL[ln] = mask;
          curR[ln] = mask;
        end else if (k == 1) begin
          curL[ln] = W'(1) << (n - 1);
          curR[ln] = 1;
        end else begin
          curL[ln] = W'($urandom) & mask;
          curR[ln] = W'($urandom) & mask;
        end
      end
      for (int h = 0; h < 2; h++) begin
        for (int p = 0; p < hl; p++) begin
          logic lr;
          bit expStrobe;
          @(negedge clkBit);
          // observe the result of the previous rising edge
          expStrobe = (k >= 1 && h == 0 && p == 1);
          if (expStrobe || pcmValid)
            check(pcmValid === expStrobe, "R8 strobe timing", NL*2*W'(pcmValid), NL*2*W'(expStrobe));
          if (expStrobe)
            check(pcmData === expPack(n), tagFmt, pcmData, expPack(n));
          if (k >= 1 && h == 1 && p == hl - 1)
            check(pcmData === expPack(n), "R8 data held", pcmData, expPack(n));

          lr = (h == 0) ? leftLvl : ~leftLvl;
          // decode serial output as I2S
          if (oCnt > 0) begin
            oAcc = {oAcc[W-2:0], sdOut};
            oCnt--;
            if (oCnt == 0 && oChk)
              check(oAcc === oExp, "R9 R10 pass word", NL*2*W'(oAcc), NL*2*W'(oExp));
          end else if (oChk && p > W) begin
            check(sdOut === 1'b0, "R9 padding", NL*2*W'(sdOut), '0);
          end
          if (p == 0) begin
            oCnt = W;
            if (lr == 1'b0) begin
              snapL = alignW(prevL[PASS], n);
              snapR = alignW(prevR[PASS], n);
              snapValid = (k >= 1);
              oExp = snapL;
            end else begin
              oExp = snapR;
            end
            oChk = snapValid;
          end

          frameClk = lr;
          for (int ln = 0; ln < NL; ln++) begin
            logic [W-1:0] w = (h == 0) ? curL[ln] : curR[ln];
            sdIn[ln] = bitFor(fmt, n, hl, p, w, prevLsb[ln], 1'($urandom));
            if (p == hl - 1) prevLsb[ln] = w[0];
          end
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int fmt = 0; fmt < 3; fmt++)
      for (int l = 0; l < 3; l++)
        for (int s = 0; s < 2; s++)
          runMode(fmt, l, (s == 0) ? 24 : 32, 7);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired R8 actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule